// File: doc/BRIEF.md
# Two-Gain Loop Filter for Time-Counter Rate Correction

This block turns each clock-synchronisation event into a signed correction for the increment of a local time counter. For every event it receives two timestamps. The first is the reference (host) time carried by the synchronisation message. The second is the local time latched when that message arrived. Their difference is the offset measurement.

The offset feeds two paths. The coarse path is a proportional term: the offset shifted right arithmetically by a programmable amount. The fine path shifts the offset by its own programmable amount and adds the result to a signed integrator, which forms the integral term. Each path has its own enable. The correction is the sum of the enabled terms, clamped to the signed output range. Exactly one correction is produced per event, and it is held on `adj` until the next one. A typical setting is both paths enabled with a shift of 2 on each.

Events are rare compared with the clock, so the data path has no back-pressure. Every `sync_valid` pulse is accepted, including pulses on back-to-back cycles. Each pulse yields exactly one `adj_valid` pulse two cycles later. The downstream counter must take the correction in the cycle it is flagged.

Top module: `dpll_freq_adj`

## Requirements
- R1: The offset is `host_ts - local_ts`, taken as a signed difference of the two unsigned timestamps and clamped to the `DW`-bit signed range. A host time below the local time gives a negative offset.
- R2: `adj_valid` is high for exactly one cycle, two clock cycles after each cycle in which `sync_valid` is high. Consecutive `sync_valid` cycles give consecutive `adj_valid` cycles, and there are no other pulses.
- R3: When `gain_en[0]` is 1, the proportional term is the offset arithmetically shifted right by `coarse_shift` (0 to 15), which rounds toward minus infinity. When `gain_en[0]` is 0, this term is zero.
- R4: When `gain_en[1]` is 1, each event adds the offset arithmetically shifted right by `fine_shift` (0 to 15) to the integrator. The correction issued for that event uses the updated integrator.
- R5: An event with `gain_en[1]` = 0 clears the integrator to zero. Integration restarts from zero when the path is enabled again.
- R6: When `gain_en` is 0, the correction is zero.
- R7: The integrator saturates at the `DW`-bit signed limits and never wraps.
- R8: The sum of the two terms saturates at the `DW`-bit signed limits and never wraps.
- R9: The enables, shifts and timestamps are sampled in the `sync_valid` cycle. Later changes to them do not alter that event's correction.
- R10: After reset, `adj_valid` is 0, `adj` is 0 and the integrator is 0.
- R11: The integrator and `adj` do not change in cycles with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_valid | input | 1 | One-cycle strobe marking a synchronisation event |
| host_ts | input | TS_W | Reference timestamp carried by the event (ns) |
| local_ts | input | TS_W | Local timestamp latched at event arrival (ns) |
| gain_en | input | 2 | Bit 0 enables the coarse path, bit 1 enables the fine path |
| coarse_shift | input | 4 | Right-shift amount for the proportional term |
| fine_shift | input | 4 | Right-shift amount for the integrator input |
| adj_valid | output | 1 | One-cycle strobe: a new correction is on `adj` |
| adj | output | DW | Signed increment correction, held between events |

## Verification
A correction is due exactly two cycles after its `sync_valid` cycle. One register stage captures the offset and the settings, and a second registers the loop result. The bench drives inputs on the falling edge. It checks that `adj_valid` is still low one falling edge after the strobe, then checks `adj_valid` and `adj` on the following falling edge. For back-to-back strobes it expects each result on successive falling edges, two behind its event. During idle stretches it confirms that `adj` holds and no strobe appears, and the next event proves the integrator was left untouched.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  localparam int SHIFT_W = 4;

  typedef struct packed {
    logic               fine_en;
    logic               coarse_en;
    logic [SHIFT_W-1:0] coarse_sh;
    logic [SHIFT_W-1:0] fine_sh;
  } loop_cfg_t;
endpackage

// File: rtl/dpll_sat.sv
module dpll_sat #(
  parameter int IN_W  = 33,
  parameter int OUT_W = 32
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  generate
    if (IN_W <= OUT_W) begin : g_ext
      assign dout = OUT_W'(din);
    end else begin : g_clamp
      localparam logic [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
      localparam logic [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};
      logic fits;
      assign fits = (&din[IN_W-1:OUT_W-1]) | ~(|din[IN_W-1:OUT_W-1]);
      assign dout = fits ? din[OUT_W-1:0] : (din[IN_W-1] ? MIN_V : MAX_V);
    end
  endgenerate
endmodule

// File: rtl/dpll_offset.sv
module dpll_offset
  import dpll_pkg::*;
#(
  parameter int TS_W = 48,
  parameter int DW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_valid,
  input  logic [TS_W-1:0]      host_ts,
  input  logic [TS_W-1:0]      local_ts,
  input  loop_cfg_t            cfg_in,
  output logic                 s1_valid,
  output logic signed [DW-1:0] s1_off,
  output loop_cfg_t            s1_cfg
);
  logic signed [TS_W:0]   diff;
  logic signed [DW-1:0]   diff_sat;

  assign diff = $signed({1'b0, host_ts}) - $signed({1'b0, local_ts});

  dpll_sat #(.IN_W(TS_W+1), .OUT_W(DW)) i_off_sat (
    .din (diff),
    .dout(diff_sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_off   <= '0;
      s1_cfg   <= '0;
    end else begin
      s1_valid <= sync_valid;
      if (sync_valid) begin
        s1_off <= diff_sat;
        s1_cfg <= cfg_in;
      end
    end
  end

  // R1: offset sign follows the ordering of the two timestamps
  p_off_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (s1_off[DW-1] == $past(host_ts < local_ts)));
endmodule

// File: rtl/dpll_loop.sv
module dpll_loop
  import dpll_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_valid,
  input  logic signed [DW-1:0] s1_off,
  input  loop_cfg_t            s1_cfg,
  output logic                 adj_valid,
  output logic signed [DW-1:0] adj
);
  logic signed [DW-1:0] integ_q;
  logic signed [DW-1:0] p_term, i_step, i_sat, i_next, o_sat;
  logic signed [DW:0]   i_sum, o_sum;

  always_comb begin
    if (s1_cfg.coarse_en) p_term = s1_off >>> s1_cfg.coarse_sh;
    else                  p_term = '0;
    i_step = s1_off >>> s1_cfg.fine_sh;
    i_sum  = (DW+1)'(integ_q) + (DW+1)'(i_step);
  end

  dpll_sat #(.IN_W(DW+1), .OUT_W(DW)) i_int_sat (
    .din (i_sum),
    .dout(i_sat)
  );

  always_comb begin
    if (s1_cfg.fine_en) i_next = i_sat;
    else                i_next = '0;
    o_sum = (DW+1)'(p_term) + (DW+1)'(i_next);
  end

  dpll_sat #(.IN_W(DW+1), .OUT_W(DW)) i_out_sat (
    .din (o_sum),
    .dout(o_sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_valid <= 1'b0;
      adj       <= '0;
      integ_q   <= '0;
    end else begin
      adj_valid <= s1_valid;
      if (s1_valid) begin
        integ_q <= i_next;
        adj     <= o_sat;
      end
    end
  end

  // R6: both paths off gives a zero correction
  p_zero_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_cfg.coarse_en && !s1_cfg.fine_en) |=> (adj_valid && adj == '0));

  // R5: fine path off leaves the integrator cleared
  p_integ_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_cfg.fine_en) |=> (integ_q == '0));

  // R11: no event, no integrator or output movement
  p_integ_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(integ_q) && $stable(adj)));

  // R3: proportional-only correction never flips the offset sign
  p_coarse_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_cfg.coarse_en && !s1_cfg.fine_en && !s1_off[DW-1]) |=> !adj[DW-1]);
endmodule

// File: rtl/dpll_freq_adj.sv
module dpll_freq_adj
  import dpll_pkg::*;
#(
  parameter int TS_W = 48,
  parameter int DW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_valid,
  input  logic [TS_W-1:0]      host_ts,
  input  logic [TS_W-1:0]      local_ts,
  input  logic [1:0]           gain_en,
  input  logic [SHIFT_W-1:0]   coarse_shift,
  input  logic [SHIFT_W-1:0]   fine_shift,
  output logic                 adj_valid,
  output logic signed [DW-1:0] adj
);
  loop_cfg_t            cfg_in, s1_cfg;
  logic                 s1_valid;
  logic signed [DW-1:0] s1_off;

  assign cfg_in.coarse_en = gain_en[0];
  assign cfg_in.fine_en   = gain_en[1];
  assign cfg_in.coarse_sh = coarse_shift;
  assign cfg_in.fine_sh   = fine_shift;

  dpll_offset #(.TS_W(TS_W), .DW(DW)) i_offset (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_valid(sync_valid),
    .host_ts   (host_ts),
    .local_ts  (local_ts),
    .cfg_in    (cfg_in),
    .s1_valid  (s1_valid),
    .s1_off    (s1_off),
    .s1_cfg    (s1_cfg)
  );

  dpll_loop #(.DW(DW)) i_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_valid (s1_valid),
    .s1_off   (s1_off),
    .s1_cfg   (s1_cfg),
    .adj_valid(adj_valid),
    .adj      (adj)
  );

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R2: every event yields a strobe two cycles later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> ##2 adj_valid);

  // R2: no strobe without an event two cycles earlier
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2 && adj_valid) |-> $past(sync_valid, 2));
endmodule

// File: tb/test_dpll_freq_adj.sv
`timescale 1ns/1ps
module test_dpll_freq_adj;
  localparam int TS_W = 48;
  localparam int DW   = 32;
  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sync_valid = 1'b0;
  logic [TS_W-1:0]      host_ts = '0;
  logic [TS_W-1:0]      local_ts = '0;
  logic [1:0]           gain_en = 2'b00;
  logic [3:0]           coarse_shift = 4'd0;
  logic [3:0]           fine_shift = 4'd0;
  logic                 adj_valid;
  logic signed [DW-1:0] adj;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  longint m_integ = 0;

  always #2 clk = ~clk;

  dpll_freq_adj #(.TS_W(TS_W), .DW(DW)) i_dpll_freq_adj (
    .clk(clk), .rst_n(rst_n), .sync_valid(sync_valid),
    .host_ts(host_ts), .local_ts(local_ts), .gain_en(gain_en),
    .coarse_shift(coarse_shift), .fine_shift(fine_shift),
    .adj_valid(adj_valid), .adj(adj)
  );

  function automatic longint clampv(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  // Reference loop: updates model integrator, returns expected correction
  function automatic longint model(input longint host, input longint loc,
                                   input int en, input int cs, input int fs);
    longint off, p;
    off = clampv(host - loc);
    p = en[0] ? (off >>> cs) : 0;
    if (en[1]) m_integ = clampv(m_integ + (off >>> fs));
    else       m_integ = 0;
    return clampv(p + m_integ);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input longint host, input longint loc,
                       input int en, input int cs, input int fs);
    sync_valid   = 1'b1;
    host_ts      = host[TS_W-1:0];
    local_ts     = loc[TS_W-1:0];
    gain_en      = en[1:0];
    coarse_shift = cs[3:0];
    fine_shift   = fs[3:0];
  endtask

  // Isolated event; inputs are scrambled after the strobe (R9)
  task automatic send_one(input string req, input longint host, input longint loc,
                          input int en, input int cs, input int fs);
    longint exp;
    exp = model(host, loc, en, cs, fs);
    drive(host, loc, en, cs, fs);
    @(negedge clk);
    sync_valid   = 1'b0;
    gain_en      = ~gain_en;
    coarse_shift = ~coarse_shift;
    fine_shift   = ~fine_shift;
    host_ts      = host_ts ^ 48'h5A5A_0F0F_3C3C;
    check("R2 no early strobe", longint'(adj_valid), 0);
    @(negedge clk);
    check("R2 strobe at +2", longint'(adj_valid), 1);
    check(req, longint'(adj), exp);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    longint offs[3];
    longint b2b_exp[3];
    offs[0] = 1000; offs[1] = -777; offs[2] = 123456789;

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 adj_valid in reset", longint'(adj_valid), 0);
    check("R10 adj in reset", longint'(adj), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 adj_valid after reset", longint'(adj_valid), 0);
    check("R10 adj after reset", longint'(adj), 0);

    // R3 R4 R6: sweep of every enable and shift combination
    for (int en = 0; en < 4; en++)
      for (int cs = 0; cs < 16; cs++)
        for (int fs = 0; fs < 16; fs++)
          for (int k = 0; k < 3; k++)
            send_one(en == 0 ? "R6 both off" : (en == 1 ? "R3 coarse" : "R4 coarse+fine"),
                     64'd5000000 + offs[k], 64'd5000000, en, cs, fs);

    // R5: fine disable clears integrator
    send_one("R5 build", 64'd900, 64'd100, 2, 0, 1);
    send_one("R5 clear", 64'd900, 64'd100, 1, 3, 1);
    send_one("R5 restart from zero", 64'd100, 64'd100, 2, 0, 0);
    check("R5 integrator zero", longint'(adj), 0);

    // R11: idle cycles leave integrator and output untouched
    send_one("R11 build", 64'd1600, 64'd0, 2, 0, 4);
    for (int i = 0; i < 20; i++) begin
      host_ts  = 48'(i * 977);
      local_ts = 48'(i * 13);
      gain_en  = 2'(i);
      @(negedge clk);
      check("R11 no strobe", longint'(adj_valid), 0);
      check("R11 adj held", longint'(adj), 100);
    end
    send_one("R11 integrator unchanged", 64'd500, 64'd500, 2, 0, 0);

    // R7: integrator saturation both ways
    for (int i = 0; i < 3; i++)
      send_one("R7 positive saturation", 64'd1000 + MAXV, 64'd1000, 2, 0, 0);
    check("R7 at max", longint'(adj), MAXV);
    for (int i = 0; i < 4; i++)
      send_one("R7 negative saturation", 64'd10, 64'd10 + MAXV + 1, 2, 0, 0);
    check("R7 at min", longint'(adj), MINV);

    // R8: output sum saturation
    send_one("R8 reset integ", 64'd0, 64'd0, 1, 0, 0);
    send_one("R8 sum positive", 64'd0 + MAXV, 64'd0, 3, 0, 0);
    send_one("R8 sum negative", 64'd0, 64'd1 + MAXV, 3, 0, 0);
    send_one("R8 sum negative again", 64'd0, 64'd1 + MAXV, 3, 0, 0);

    // R1: wide differences clamp; sign follows ordering
    send_one("R1 large positive", 64'h0000_0100_0000_0000, 64'd0, 1, 0, 0);
    send_one("R1 large negative", 64'd0, 64'h0000_0100_0000_0000, 1, 0, 0);
    send_one("R1 small negative", 64'd1000, 64'd1003, 1, 0, 0);
    send_one("R1 max timestamps", 64'h0000_FFFF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFF0, 1, 0, 0);

    // R2 R9: back-to-back events, distinct settings each cycle
    for (int i = 0; i < 5; i++) begin
      if (i < 3) begin
        b2b_exp[i] = model(64'd70000 + i * 4321, 64'd60000, i + 1, i + 1, i);
        drive(64'd70000 + i * 4321, 64'd60000, i + 1, i + 1, i);
      end else begin
        sync_valid = 1'b0;
        gain_en    = 2'b00;
      end
      @(negedge clk);
      if (i >= 1 && i <= 3) begin
        check("R2 back-to-back strobe", longint'(adj_valid), 1);
        check("R9 back-to-back value", longint'(adj), b2b_exp[i-1]);
      end
    end
    check("R2 strobe ends", longint'(adj_valid), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule